// File: doc/BRIEF.md
# Infix to Postfix Boolean Token Converter

This block takes the tokens of a boolean expression in written (infix) order and passes them on in postfix order, ready for a stack-based evaluator further down the pipeline. Operands go out as soon as they arrive. Operators wait on an internal operator stack and leave it according to a fixed precedence: NOT binds tightest, then AND, then OR. Brackets override this precedence and are never sent to the output.

Every expression is closed by a terminator token. The converter behaves as though the expression were wrapped in an implicit pair of brackets, and the terminator acts as the closing one. The terminator is always sent on as the last output token of its expression, and `out_done` is high with it. A mode tracker checks that operands and operators alternate correctly. Bracket balance and storage limits are also checked. Each problem raises its own sticky flag, which stays set until the first token of the next expression is accepted.

Both sides use valid/ready handshakes. Input and output tokens share one encoding: a 4-bit kind and an index field that carries the number of an input signal.

Top module: `infix_postfix_conv`

## Requirements
- R1: Token kind codes are 0 constant zero, 1 constant one, 2 signal reference (index on the idx field), 3 open bracket, 4 close bracket, 5 OR, 6 AND, 7 NOT, 8 terminator. Output tokens use the same codes. After reset `in_ready` is 1, `out_valid` is 0 and all error flags are 0.
- R2: Operands are emitted in arrival order. A signal reference keeps its index. Constants are emitted with index 0.
- R3: AND binds tighter than OR. When a binary operator arrives, every stacked operator of equal or higher precedence is emitted first, so equal binary operators group from the left.
- R4: NOT binds tighter than AND. NOT applies to the operand or bracket that follows it. Consecutive NOTs nest, and the inner one is emitted first.
- R5: Brackets override precedence. Neither open nor close brackets ever appear on the output.
- R6: A terminator emits all operators still stacked, then emits itself with `out_done`=1. Exactly one token per expression carries `out_done`.
- R7: An operand, open bracket or NOT that arrives while an operator is expected sets `err_need_optr`.
- R8: An OR, AND, close bracket or terminator that arrives while an operand is expected sets `err_need_opnd`. Each expression starts out expecting an operand.
- R9: A close bracket that matches the implicit outer bracket sets `err_unmatched`. All following tokens up to the terminator are dropped, and the terminator is still emitted.
- R10: A terminator that leaves user open brackets on the stack sets `err_premature`.
- R11: The operator stack holds STACK_DEPTH (50) entries, and the implicit bracket counts as one of them. A push into a full stack is dropped and sets `err_overflow`.
- R12: At most OUT_LIMIT (50) non-terminator tokens are emitted per expression. Any further ones are dropped and set `err_overflow`.
- R13: Error flags stay set until the first token of the next expression is accepted. An output token holds steady while `out_ready` is low. Input is accepted only while the output register is free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input token valid |
| in_ready | output | 1 | Converter can accept a token |
| in_kind | input | 4 | Input token kind |
| in_idx | input | IDX_W | Signal index of input token |
| out_valid | output | 1 | Output token valid |
| out_ready | input | 1 | Consumer accepts output token |
| out_kind | output | 4 | Output token kind |
| out_idx | output | IDX_W | Signal index of output token |
| out_done | output | 1 | Marks the terminator closing an expression |
| err_need_optr | output | 1 | Operand-side token seen where an operator was expected |
| err_need_opnd | output | 1 | Operator-side token seen where an operand was expected |
| err_unmatched | output | 1 | Close bracket without a matching open bracket |
| err_premature | output | 1 | Terminator with open brackets still pending |
| err_overflow | output | 1 | Operator stack or output count limit exceeded |

## Verification
The hardest conditions to reach are the two capacity limits, because each needs a precise count of tokens. The stimulus nests exactly 49 brackets, which fills the stack, and then 50 brackets, which overflows it by one. It sends an AND chain whose emitted tokens come to exactly 50 with a leading NOT, and 51 without it, so the token dropped is the final operator flushed by the terminator. Throughout the run, a pseudo-random `out_ready` stalls the output while an operator flush is in progress, to show that no token is lost or repeated under backpressure.

// File: rtl/infix_pkg.sv
package infix_pkg;

    typedef enum logic [3:0] {
        TK_ZERO  = 4'd0,
        TK_ONE   = 4'd1,
        TK_SIG   = 4'd2,
        TK_OPEN  = 4'd3,
        TK_CLOSE = 4'd4,
        TK_OR    = 4'd5,
        TK_AND   = 4'd6,
        TK_NOT   = 4'd7,
        TK_END   = 4'd8
    } tok_kind_e;

    // Stacked operator codes; numeric order equals binding strength.
    typedef enum logic [1:0] {
        SO_OPEN = 2'd0,
        SO_OR   = 2'd1,
        SO_AND  = 2'd2,
        SO_NOT  = 2'd3
    } stk_op_e;

    function automatic stk_op_e op_of_tok(tok_kind_e k);
        case (k)
            TK_OR:   return SO_OR;
            TK_AND:  return SO_AND;
            TK_NOT:  return SO_NOT;
            default: return SO_OPEN;
        endcase
    endfunction

    function automatic tok_kind_e tok_of_op(stk_op_e o);
        case (o)
            SO_OR:   return TK_OR;
            SO_AND:  return TK_AND;
            SO_NOT:  return TK_NOT;
            default: return TK_OPEN;
        endcase
    endfunction

    function automatic logic is_operand(tok_kind_e k);
        return (k == TK_ZERO) || (k == TK_ONE) || (k == TK_SIG);
    endfunction

endpackage

// File: rtl/infix_mode_chk.sv
module infix_mode_chk
    import infix_pkg::*;
(
    input  tok_kind_e kind,
    input  logic      expect_opnd,
    output logic      bad_opnd_side,
    output logic      bad_optr_side,
    output logic      next_expect_opnd
);

    logic opnd_side;
    logic optr_side;

    always_comb begin
        opnd_side = is_operand(kind) || (kind == TK_OPEN) || (kind == TK_NOT);
        optr_side = (kind == TK_OR) || (kind == TK_AND) ||
                    (kind == TK_CLOSE) || (kind == TK_END);

        bad_opnd_side = opnd_side && !expect_opnd;
        bad_optr_side = optr_side && expect_opnd;

        next_expect_opnd = expect_opnd;
        if (is_operand(kind)) begin
            next_expect_opnd = 1'b0;
        end else if ((kind == TK_OR) || (kind == TK_AND) ||
                     (kind == TK_OPEN) || (kind == TK_NOT)) begin
            next_expect_opnd = 1'b1;
        end else if ((kind == TK_CLOSE) || (kind == TK_END)) begin
            next_expect_opnd = 1'b0;
        end
    end

endmodule

// File: rtl/infix_op_stack.sv
module infix_op_stack
    import infix_pkg::*;
#(
    parameter int DEPTH = 50,
    parameter int SP_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             reinit,
    input  stk_op_e          push_op,
    output stk_op_e          top_op,
    output logic [SP_W-1:0]  depth,
    output logic             full
);

    localparam logic [SP_W-1:0] FULL_SP = SP_W'(DEPTH);
    localparam logic [SP_W-1:0] ONE_SP  = SP_W'(1);

    typedef struct packed {
        stk_op_e [DEPTH-1:0] mem;
        logic [SP_W-1:0]     sp;
    } stk_t;

    stk_t stk_q, stk_d;

    always_comb begin
        stk_d = stk_q;
        if (reinit) begin
            // Fresh expression: only the implicit outer bracket remains.
            stk_d.mem[0] = SO_OPEN;
            stk_d.sp     = ONE_SP;
        end else if (pop && (stk_q.sp != '0)) begin
            stk_d.sp = stk_q.sp - ONE_SP;
        end else if (push && (stk_q.sp != FULL_SP)) begin
            stk_d.mem[stk_q.sp] = push_op;
            stk_d.sp            = stk_q.sp + ONE_SP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= stk_t'({{(2*DEPTH){1'b0}}, ONE_SP});
        end else begin
            stk_q <= stk_d;
        end
    end

    always_comb begin
        top_op = (stk_q.sp == '0) ? SO_OPEN : stk_q.mem[stk_q.sp - ONE_SP];
        depth  = stk_q.sp;
        full   = (stk_q.sp == FULL_SP);
    end

endmodule

// File: rtl/infix_postfix_conv.sv
module infix_postfix_conv
    import infix_pkg::*;
#(
    parameter int IDX_W       = 4,
    parameter int STACK_DEPTH = 50,
    parameter int OUT_LIMIT   = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [3:0]       in_kind,
    input  logic [IDX_W-1:0] in_idx,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [3:0]       out_kind,
    output logic [IDX_W-1:0] out_idx,
    output logic             out_done,
    output logic             err_need_optr,
    output logic             err_need_opnd,
    output logic             err_unmatched,
    output logic             err_premature,
    output logic             err_overflow
);

    localparam int SP_W  = $clog2(STACK_DEPTH + 1);
    localparam int CNT_W = $clog2(OUT_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(OUT_LIMIT);
    localparam logic [SP_W-1:0]  SP_ONE  = SP_W'(1);

    typedef enum logic {PH_TAKE, PH_FLUSH} phase_e;

    typedef struct packed {
        phase_e           ph;
        tok_kind_e        cur;
        logic             exp_opnd;
        logic             discard;
        logic             fresh;
        logic             ov;
        tok_kind_e        ok;
        logic [IDX_W-1:0] oi;
        logic             od;
        logic [CNT_W-1:0] cnt;
        logic             e_a;
        logic             e_b;
        logic             e_unm;
        logic             e_pre;
        logic             e_ovf;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    // Stack control
    logic            stk_push, stk_pop, stk_reinit, stk_full;
    stk_op_e         stk_push_op, stk_top;
    logic [SP_W-1:0] stk_depth;

    // Mode tracker
    tok_kind_e tok_in;
    logic      mode_bad_a, mode_bad_b, mode_next;

    logic out_free;
    logic take;

    assign tok_in = tok_kind_e'(in_kind);

    infix_op_stack #(
        .DEPTH (STACK_DEPTH),
        .SP_W  (SP_W)
    ) stack_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (stk_push),
        .pop     (stk_pop),
        .reinit  (stk_reinit),
        .push_op (stk_push_op),
        .top_op  (stk_top),
        .depth   (stk_depth),
        .full    (stk_full)
    );

    infix_mode_chk mode_i (
        .kind             (tok_in),
        .expect_opnd      (ctl_q.exp_opnd),
        .bad_opnd_side    (mode_bad_a),
        .bad_optr_side    (mode_bad_b),
        .next_expect_opnd (mode_next)
    );

    function automatic ctl_t put_tok(ctl_t s, tok_kind_e k, logic [IDX_W-1:0] i);
        ctl_t r = s;
        if (r.cnt == CNT_LIM) begin
            r.e_ovf = 1'b1;
        end else begin
            r.ov  = 1'b1;
            r.ok  = k;
            r.oi  = i;
            r.od  = 1'b0;
            r.cnt = r.cnt + 1'b1;
        end
        return r;
    endfunction

    function automatic ctl_t put_end(ctl_t s);
        ctl_t r = s;
        r.ov       = 1'b1;
        r.ok       = TK_END;
        r.oi       = '0;
        r.od       = 1'b1;
        r.ph       = PH_TAKE;
        r.exp_opnd = 1'b1;
        r.fresh    = 1'b1;
        r.discard  = 1'b0;
        return r;
    endfunction

    always_comb begin
        ctl_d       = ctl_q;
        stk_push    = 1'b0;
        stk_pop     = 1'b0;
        stk_reinit  = 1'b0;
        stk_push_op = SO_OPEN;

        out_free = !ctl_q.ov || out_ready;
        in_ready = (ctl_q.ph == PH_TAKE) && out_free;
        take     = in_valid && in_ready;

        if (ctl_q.ov && out_ready) begin
            ctl_d.ov = 1'b0;
        end

        if (take) begin
            if (ctl_q.fresh) begin
                ctl_d.fresh = 1'b0;
                ctl_d.cnt   = '0;
                ctl_d.e_a   = 1'b0;
                ctl_d.e_b   = 1'b0;
                ctl_d.e_unm = 1'b0;
                ctl_d.e_pre = 1'b0;
                ctl_d.e_ovf = 1'b0;
            end
            if (ctl_q.discard) begin
                if (tok_in == TK_END) begin
                    ctl_d      = put_end(ctl_d);
                    stk_reinit = 1'b1;
                end
            end else begin
                ctl_d.e_a      = ctl_d.e_a | mode_bad_a;
                ctl_d.e_b      = ctl_d.e_b | mode_bad_b;
                ctl_d.exp_opnd = mode_next;
                case (tok_in)
                    TK_ZERO, TK_ONE: ctl_d = put_tok(ctl_d, tok_in, '0);
                    TK_SIG:          ctl_d = put_tok(ctl_d, tok_in, in_idx);
                    TK_OPEN, TK_NOT: begin
                        // Prefix items never flush anything below them.
                        if (stk_full) begin
                            ctl_d.e_ovf = 1'b1;
                        end else begin
                            stk_push    = 1'b1;
                            stk_push_op = op_of_tok(tok_in);
                        end
                    end
                    TK_OR, TK_AND, TK_CLOSE, TK_END: begin
                        ctl_d.cur = tok_in;
                        ctl_d.ph  = PH_FLUSH;
                    end
                    default: ;
                endcase
            end
        end else if ((ctl_q.ph == PH_FLUSH) && out_free) begin
            if (stk_depth == '0) begin
                if (ctl_q.cur == TK_END) begin
                    ctl_d      = put_end(ctl_d);
                    stk_reinit = 1'b1;
                end else begin
                    ctl_d.e_unm   = 1'b1;
                    ctl_d.discard = 1'b1;
                    ctl_d.ph      = PH_TAKE;
                end
            end else if ((ctl_q.cur == TK_OR) || (ctl_q.cur == TK_AND)) begin
                if (stk_top >= op_of_tok(ctl_q.cur)) begin
                    stk_pop = 1'b1;
                    ctl_d   = put_tok(ctl_d, tok_of_op(stk_top), '0);
                end else begin
                    if (stk_full) begin
                        ctl_d.e_ovf = 1'b1;
                    end else begin
                        stk_push    = 1'b1;
                        stk_push_op = op_of_tok(ctl_q.cur);
                    end
                    ctl_d.ph = PH_TAKE;
                end
            end else if (stk_top == SO_OPEN) begin
                stk_pop = 1'b1;
                if (ctl_q.cur == TK_CLOSE) begin
                    if (stk_depth == SP_ONE) begin
                        ctl_d.e_unm   = 1'b1;
                        ctl_d.discard = 1'b1;
                    end
                    ctl_d.ph = PH_TAKE;
                end else begin
                    if (stk_depth != SP_ONE) begin
                        ctl_d.e_pre = 1'b1;
                    end
                    ctl_d      = put_end(ctl_d);
                    stk_reinit = 1'b1;
                end
            end else begin
                stk_pop = 1'b1;
                ctl_d   = put_tok(ctl_d, tok_of_op(stk_top), '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.ph       <= PH_TAKE;
            ctl_q.exp_opnd <= 1'b1;
            ctl_q.fresh    <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign out_valid     = ctl_q.ov;
    assign out_kind      = ctl_q.ok;
    assign out_idx       = ctl_q.oi;
    assign out_done      = ctl_q.od;
    assign err_need_optr = ctl_q.e_a;
    assign err_need_opnd = ctl_q.e_b;
    assign err_unmatched = ctl_q.e_unm;
    assign err_premature = ctl_q.e_pre;
    assign err_overflow  = ctl_q.e_ovf;

endmodule

// File: rtl/infix_postfix_conv_chk.sv
module infix_postfix_conv_chk #(
    parameter int STACK_DEPTH = 50,
    parameter int SP_W        = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic [3:0]      out_kind,
    input logic            out_done,
    input logic            e_a,
    input logic            e_b,
    input logic            e_unm,
    input logic            e_pre,
    input logic            e_ovf,
    input logic [SP_W-1:0] stk_depth
);

    logic [4:0] errs;
    assign errs = {e_ovf, e_pre, e_unm, e_b, e_a};

    // R6: the done marker travels only with the terminator, and always with it
    p_done_with_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_done == (out_kind == 4'd8)));

    // R5: brackets never reach the output
    p_no_bracket_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_kind != 4'd3) && (out_kind != 4'd4)));

    // R13: a stalled output token is held unchanged
    p_hold_stalled_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_done)));

    // R13: raised flags do not drop without an accepted input token
    p_flags_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> ((errs & $past(errs)) == $past(errs)));

    // R13: input accepted only while the output register can take a token
    p_ready_gate_r13: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!out_valid || out_ready));

    // R11: stack occupancy never exceeds its capacity
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_depth <= SP_W'(STACK_DEPTH));

endmodule

bind infix_postfix_conv infix_postfix_conv_chk #(
    .STACK_DEPTH (STACK_DEPTH),
    .SP_W        (SP_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_kind  (out_kind),
    .out_done  (out_done),
    .e_a       (err_need_optr),
    .e_b       (err_need_opnd),
    .e_unm     (err_unmatched),
    .e_pre     (err_premature),
    .e_ovf     (err_overflow),
    .stk_depth (stk_depth)
);

// File: tb/infix_postfix_conv_tb_top.sv
module infix_postfix_conv_tb_top;

    localparam int IDX_W = 4;
    localparam logic [4:0] E_A   = 5'b00001;
    localparam logic [4:0] E_B   = 5'b00010;
    localparam logic [4:0] E_UNM = 5'b00100;
    localparam logic [4:0] E_PRE = 5'b01000;
    localparam logic [4:0] E_OVF = 5'b10000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [3:0] in_kind = '0;
    logic [IDX_W-1:0] in_idx = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [3:0] out_kind;
    logic [IDX_W-1:0] out_idx;
    logic out_done;
    logic err_need_optr, err_need_opnd, err_unmatched, err_premature, err_overflow;
    logic [4:0] errs;

    int n_total = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [3:0]       k;
        logic [IDX_W-1:0] i;
        logic             d;
        logic [4:0]       e;
        string            tag;
    } exp_t;

    exp_t sbq[$];

    always #2 clk = ~clk;

    assign errs = {err_overflow, err_premature, err_unmatched, err_need_opnd, err_need_optr};

    infix_postfix_conv #(.IDX_W(IDX_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_kind       (in_kind),
        .in_idx        (in_idx),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_kind      (out_kind),
        .out_idx       (out_idx),
        .out_done      (out_done),
        .err_need_optr (err_need_optr),
        .err_need_opnd (err_need_opnd),
        .err_unmatched (err_unmatched),
        .err_premature (err_premature),
        .err_overflow  (err_overflow)
    );

    function automatic logic [3:0] ch_kind(byte c);
        case (c)
            "0": return 4'd0;
            "1": return 4'd1;
            "(": return 4'd3;
            ")": return 4'd4;
            "+": return 4'd5;
            ".": return 4'd6;
            "~": return 4'd7;
            default: return 4'd2;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] ch_idx(byte c);
        if (c >= "a" && c <= "p") return IDX_W'(c - "a");
        return '0;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic report_end();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    endtask

    task automatic send_tok(logic [3:0] k, logic [IDX_W-1:0] i);
        @(negedge clk);
        in_valid = 1'b1;
        in_kind  = k;
        in_idx   = i;
        forever begin
            #1;
            if (in_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    int gap_ctr = 0;

    task automatic run_expr(string infix, string postfix, logic [4:0] e, string tag);
        exp_t x;
        for (int p = 0; p < postfix.len(); p++) begin
            x.k = ch_kind(postfix[p]); x.i = ch_idx(postfix[p]);
            x.d = 1'b0; x.e = '0; x.tag = tag;
            sbq.push_back(x);
        end
        x.k = 4'd8; x.i = '0; x.d = 1'b1; x.e = e; x.tag = tag;
        sbq.push_back(x);
        for (int p = 0; p < infix.len(); p++) begin
            send_tok(ch_kind(infix[p]), ch_idx(infix[p]));
            gap_ctr++;
            if (gap_ctr % 3 == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        send_tok(4'd8, '0);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: backpressure and scoreboard comparison
    logic [7:0] lf = 8'h5a;
    initial begin
        forever begin
            @(negedge clk);
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            out_ready = lf[0] | lf[1];
            #1;
            if (rst_n && out_valid && out_ready) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R6", "unexpected output token", int'(out_kind), 0);
                end else begin
                    exp_t x;
                    x = sbq.pop_front();
                    check(out_kind == x.k, x.tag, "kind", int'(out_kind), int'(x.k));
                    check(out_idx == x.i, x.tag, "idx", int'(out_idx), int'(x.i));
                    check(out_done == x.d, x.tag, "done", int'(out_done), int'(x.d));
                    if (x.d) check(errs == x.e, x.tag, "error flags", int'(errs), int'(x.e));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_bad++;
        $display("FAIL watchdog expired, pending=%0d expected=0", sbq.size());
        report_end();
    end

    initial begin
        string s, t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
        check(errs == 5'b0, "R1", "reset flags", int'(errs), 0);

        run_expr("a+b.c", "abc.+", '0, "R3");
        run_expr("a.b+c", "ab.c+", '0, "R3");
        run_expr("a+b+c", "ab+c+", '0, "R3");
        run_expr("0.1.k", "01.k.", '0, "R1");
        run_expr("p", "p", '0, "R2");
        run_expr("(a+b).c", "ab+c.", '0, "R5");
        run_expr("~a.b", "a~b.", '0, "R4");
        run_expr("~~a", "a~~", '0, "R4");
        run_expr("~(a+b)", "ab+~", '0, "R4");
        run_expr("c", "c", '0, "R6");
        run_expr("ab", "ab", E_A, "R7");
        run_expr("a+", "a+", E_B, "R8");
        run_expr("+a", "a+", E_B, "R8");
        run_expr("a)+b", "a", E_UNM, "R9");
        run_expr("(a", "a", E_PRE, "R10");
        run_expr("a.b", "ab.", '0, "R13");

        // R11: 49 user brackets fill the stack exactly; 50 overflow it
        s = "";
        for (int n = 0; n < 49; n++) s = {s, "("};
        t = {s, "a"};
        for (int n = 0; n < 49; n++) t = {t, ")"};
        run_expr(t, "a", '0, "R11");
        run_expr({s, "(a"}, "a", E_OVF | E_PRE, "R11");

        // R12: exactly 50 emitted tokens, then 51 with the last one dropped
        s = "~a"; t = "a~";
        for (int n = 0; n < 24; n++) begin s = {s, ".a"}; t = {t, "a."}; end
        run_expr(s, t, '0, "R12");
        s = "a"; t = "a";
        for (int n = 0; n < 25; n++) begin s = {s, ".a"}; t = {t, "a."}; end
        t = t.substr(0, t.len() - 2);
        run_expr(s, t, E_OVF, "R12");
        run_expr("b+c", "bc+", '0, "R13");

        while (sbq.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        report_end();
    end

endmodule